// File: doc/BRIEF.md
# Bad-Block Result Browser Display

This block shows the outcome of a flash bad-block scan on eight multiplexed seven-segment digits of the common-anode type. The scan logic supplies the total number of bad blocks as a plain level. The block keeps an index into the list of bad-block addresses that the scan left in a result memory. It reads the entry at that index through a synchronous read port with one cycle of latency. The first two digits show the count in decimal. The last three digits show the selected block address in hexadecimal. The digits in between stay dark.

Two push buttons, up and down, step the index through the list. Each button input is synchronised and debounced, and only its press edge is used, so one press moves the selection by exactly one entry. The digits are lit one at a time, each for a parameterised dwell time. Segments and selects are all switched off for one cycle at every digit change to avoid ghosting.

The read port has a fixed latency and accepts a request every cycle, so it carries no valid/ready handshake and there is no back-pressure. The address is held steady for as long as the index does not move. Every other pin is plain control or status.

Top module: `bbdisp_top`

## Requirements
- R1: While rst_n is low, all select lines and all segment lines are high (dark), and the index restarts at entry 0.
- R2: At most one digit_sel_n bit is low at a time. The lit digit advances 0,1,...,7,0 in order, and digit k is selected by driving bit k low.
- R3: At every change of lit digit, there is a cycle with all selects high, and all segments stay high whenever no digit is selected.
- R4: Digits 0 and 1 show the tens and units of the count in decimal. A count above 99 shows as 99.
- R5: Digits 5, 6 and 7 show bits [11:8], [7:4] and [3:0] of the memory entry at the current index, in hexadecimal.
- R6: With a count of zero, digits 5 to 7 show a dash (segment g only), the index is 0 and mem_rd_en is low.
- R7: Digits 2, 3 and 4 are always blank (all segments high).
- R8: Each up press raises the index by one. The index stops at count-1.
- R9: Each down press lowers the index by one. The index stops at 0.
- R10: A button level shorter than DB_CYC cycles has no effect, and a press held for many debounce periods moves the index only once.
- R11: If the count falls to or below the index, the index is pulled to count-1 on the next cycle.
- R12: seg_n[6:0] is {g,f,e,d,c,b,a}, active low. The glyph codes (active-high hex) for digits 0-F are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71. A dash is 40 and a blank is 00.
- R13: mem_rd_addr always carries the current index, and mem_rd_en is high whenever the count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bad_count | input | CNT_W | Number of bad blocks found by the scan |
| btn_up | input | 1 | Raw up button, high when pressed |
| btn_dn | input | 1 | Raw down button, high when pressed |
| mem_rd_en | output | 1 | Result memory read enable |
| mem_rd_addr | output | CNT_W | Result memory read address (list index) |
| mem_rd_data | input | BLK_W | Result memory read data, one cycle after the request |
| digit_sel_n | output | 8 | Digit selects, active low |
| seg_n | output | 7 | Segments {g..a}, active low |

## Verification
The bench drives the index into both ends of the list and presses again there. A design that wrapped or ran past the end would show the wrong address or read out of range. It sends a button glitch shorter than the debounce window and holds a long press. A weak debouncer would step on the glitch or step repeatedly on the hold. It also uses a count of zero, a count above 99, and a count that shrinks under the current index. A design that got these wrong would show a stale address instead of dashes, show three-digit garbage in the decimal field, or keep reading beyond the list. A monitor watches every digit change and flags two digits lit back to back without the dark cycle between them.

// File: rtl/bbdisp_pkg.sv
package bbdisp_pkg;
  localparam int NDIG = 8;
  localparam logic [6:0] GLYPH_BLANK = 7'h00;
  localparam logic [6:0] GLYPH_DASH  = 7'h40;

  // active-high {g,f,e,d,c,b,a} pattern for one hex nibble
  function automatic logic [6:0] hex_glyph(input logic [3:0] nib);
    logic [6:0] g;
    case (nib)
      4'h0: g = 7'h3F; 4'h1: g = 7'h06; 4'h2: g = 7'h5B; 4'h3: g = 7'h4F;
      4'h4: g = 7'h66; 4'h5: g = 7'h6D; 4'h6: g = 7'h7D; 4'h7: g = 7'h07;
      4'h8: g = 7'h7F; 4'h9: g = 7'h6F; 4'hA: g = 7'h77; 4'hB: g = 7'h7C;
      4'hC: g = 7'h39; 4'hD: g = 7'h5E; 4'hE: g = 7'h79; default: g = 7'h71;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/bbdisp_btn.sv
module bbdisp_btn #(
  parameter int DB_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic press
);
  localparam int DBW = $clog2(DB_CYC + 1);

  logic [1:0]     sync_q;
  logic           stable_q;
  logic [DBW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= '0;
      stable_q <= 1'b0;
      cnt_q    <= '0;
      press    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw};
      press  <= 1'b0;
      if (sync_q[1] == stable_q) begin
        cnt_q <= '0;
      end else if (cnt_q == DBW'(DB_CYC - 1)) begin
        cnt_q    <= '0;
        stable_q <= sync_q[1];
        press    <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bbdisp_scan.sv
module bbdisp_scan #(
  parameter int DWELL = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [2:0] digit,
  output logic       blank
);
  localparam int DW = $clog2(DWELL + 1);

  logic [DW-1:0] dwell_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dwell_q <= '0;
      digit   <= '0;
    end else if (dwell_q == DW'(DWELL - 1)) begin
      dwell_q <= '0;
      digit   <= digit + 1'b1;
    end else begin
      dwell_q <= dwell_q + 1'b1;
    end
  end

  assign blank = (dwell_q == '0);
endmodule

// File: rtl/bbdisp_idx.sv
module bbdisp_idx #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             up_p,
  input  logic             dn_p,
  output logic [CNT_W-1:0] idx
);
  logic [CNT_W-1:0] last;
  assign last = count - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)                              idx <= '0;
    else if (count == '0)                    idx <= '0;
    else if (idx > last)                     idx <= last;
    else if (up_p && !dn_p && idx < last)    idx <= idx + 1'b1;
    else if (dn_p && !up_p && idx != '0)     idx <= idx - 1'b1;
  end
endmodule

// File: rtl/bbdisp_top.sv
module bbdisp_top
  import bbdisp_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int BLK_W  = 12,
  parameter int DWELL  = 2000,
  parameter int DB_CYC = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] bad_count,
  input  logic             btn_up,
  input  logic             btn_dn,
  output logic             mem_rd_en,
  output logic [CNT_W-1:0] mem_rd_addr,
  input  logic [BLK_W-1:0] mem_rd_data,
  output logic [7:0]       digit_sel_n,
  output logic [6:0]       seg_n
);
  localparam int ADDR_DIG = 3;

  logic       up_p, dn_p;
  logic [2:0] digit;
  logic       blank;
  logic [CNT_W-1:0] idx;

  bbdisp_btn #(.DB_CYC(DB_CYC)) u_btn_up (.clk(clk), .rst_n(rst_n), .raw(btn_up), .press(up_p));
  bbdisp_btn #(.DB_CYC(DB_CYC)) u_btn_dn (.clk(clk), .rst_n(rst_n), .raw(btn_dn), .press(dn_p));
  bbdisp_scan #(.DWELL(DWELL)) u_scan (.clk(clk), .rst_n(rst_n), .digit(digit), .blank(blank));
  bbdisp_idx #(.CNT_W(CNT_W)) u_idx (.clk(clk), .rst_n(rst_n), .count(bad_count),
                                     .up_p(up_p), .dn_p(dn_p), .idx(idx));

  assign mem_rd_addr = idx;
  assign mem_rd_en   = (bad_count != '0);

  // decimal count field, saturated at two digits
  logic [6:0] cnt_sat, tens, ones;
  always_comb begin
    cnt_sat = (32'(bad_count) > 32'd99) ? 7'd99 : 7'(bad_count);
    tens    = cnt_sat / 7'd10;
    ones    = cnt_sat - tens * 7'd10;
  end

  logic [4*ADDR_DIG-1:0] blk_ext;
  assign blk_ext = (4*ADDR_DIG)'(mem_rd_data);

  logic [6:0] glyph;
  always_comb begin
    glyph = GLYPH_BLANK;
    case (digit)
      3'd0: glyph = hex_glyph(tens[3:0]);
      3'd1: glyph = hex_glyph(ones[3:0]);
      3'd5, 3'd6, 3'd7: begin
        if (bad_count == '0) glyph = GLYPH_DASH;
        else                 glyph = hex_glyph(blk_ext[4*(3'd7 - digit) +: 4]);
      end
      default: glyph = GLYPH_BLANK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      digit_sel_n <= '1;
      seg_n       <= '1;
    end else if (blank) begin
      digit_sel_n <= '1;
      seg_n       <= '1;
    end else begin
      digit_sel_n <= ~(8'b1 << digit);
      seg_n       <= ~glyph;
    end
  end
endmodule

// File: rtl/bbdisp_chk.sv
module bbdisp_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] bad_count,
  input logic [CNT_W-1:0] mem_rd_addr,
  input logic [7:0]       digit_sel_n,
  input logic [6:0]       seg_n
);
  p_one_lit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~digit_sel_n));

  p_dark_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_sel_n != 8'hFF) |=> (digit_sel_n == 8'hFF || $stable(digit_sel_n)));

  p_dark_seg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_sel_n == 8'hFF) |-> (seg_n == 7'h7F));

  p_idx_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(bad_count) && bad_count != '0) |-> (mem_rd_addr < bad_count));

  p_zero_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(bad_count) && bad_count == '0) |-> (mem_rd_addr == '0));
endmodule

bind bbdisp_top bbdisp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bad_count(bad_count), .mem_rd_addr(mem_rd_addr),
  .digit_sel_n(digit_sel_n), .seg_n(seg_n));

// File: tb/test_bbdisp_top.sv
module test_bbdisp_top;
  localparam int CNT_W = 8;
  localparam int DWELL = 6;
  localparam int DB    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] bad_count = '0;
  logic btn_up = 1'b0, btn_dn = 1'b0;
  logic mem_rd_en;
  logic [CNT_W-1:0] mem_rd_addr;
  logic [11:0] mem_rd_data = '0;
  logic [7:0] digit_sel_n;
  logic [6:0] seg_n;

  int checks = 0, errors = 0;
  int exp_idx = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bbdisp_top #(.CNT_W(CNT_W), .BLK_W(12), .DWELL(DWELL), .DB_CYC(DB)) i_bbdisp_top (
    .clk(clk), .rst_n(rst_n), .bad_count(bad_count), .btn_up(btn_up), .btn_dn(btn_dn),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .digit_sel_n(digit_sel_n), .seg_n(seg_n));

  function automatic logic [11:0] mem_val(input int i);
    return 12'h3A5 ^ 12'(i * 12'h1C7);
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_val(int'(mem_rd_addr));

  function automatic logic [6:0] glyph(input logic [3:0] n);
    logic [6:0] t [16] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,
                           7'h7F,7'h6F,7'h77,7'h7C,7'h39,7'h5E,7'h79,7'h71};
    return t[n];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard: expected {digit, active-low segments}
  logic [9:0] sb_q[$];
  string      sb_tag[$];

  task automatic expect_frame(input int cnt, input int idx, input string tag);
    int c = (cnt > 99) ? 99 : cnt;
    logic [11:0] a = mem_val(idx);
    for (int d = 0; d < 8; d++) begin
      logic [6:0] g;
      string t;
      case (d)
        0: begin g = glyph(4'(c / 10)); t = {tag, " R4"}; end
        1: begin g = glyph(4'(c % 10)); t = {tag, " R4"}; end
        5, 6, 7: begin
          g = (cnt == 0) ? 7'h40 : glyph(a[4*(7-d) +: 4]);
          t = (cnt == 0) ? {tag, " R6"} : {tag, " R5 R12"};
        end
        default: begin g = 7'h00; t = {tag, " R7"}; end
      endcase
      sb_q.push_back({3'(d), ~g});
      sb_tag.push_back(t);
    end
    wait (sb_q.size() == 0);
    @(negedge clk);
    check(mem_rd_addr == CNT_W'(exp_idx), {tag, " R13 addr"}, int'(mem_rd_addr), exp_idx);
    check(mem_rd_en == (cnt != 0), {tag, " R13 en"}, int'(mem_rd_en), int'(cnt != 0));
  endtask

  // monitor
  logic [7:0] prev_s = 8'hFF;
  int last_lit = -1;
  always @(negedge clk) begin
    if (rst_n) begin
      int d = -1;
      for (int k = 0; k < 8; k++) if (!digit_sel_n[k]) d = k;
      if (digit_sel_n != prev_s) begin
        if (digit_sel_n != 8'hFF) begin
          check($countones(~digit_sel_n) == 1, "R2 single digit", int'(digit_sel_n), 0);
          check(prev_s == 8'hFF, "R3 dark gap", int'(prev_s), 8'hFF);
          if (last_lit >= 0)
            check(d == (last_lit + 1) % 8, "R2 order", d, (last_lit + 1) % 8);
          last_lit = d;
        end else begin
          check(seg_n == 7'h7F, "R3 dark segments", int'(seg_n), 8'h7F);
        end
      end
      prev_s = digit_sel_n;
      if (d >= 0 && sb_q.size() > 0 && int'(sb_q[0][9:7]) == d) begin
        check(seg_n == sb_q[0][6:0], sb_tag[0], int'(seg_n), int'(sb_q[0][6:0]));
        void'(sb_q.pop_front());
        void'(sb_tag.pop_front());
      end
    end
  end

  task automatic press(input bit up, input int hold);
    if (up) btn_up = 1'b1; else btn_dn = 1'b1;
    repeat (hold) @(negedge clk);
    btn_up = 1'b0; btn_dn = 1'b0;
    repeat (DB * 3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    check(digit_sel_n == 8'hFF, "R1 selects", int'(digit_sel_n), 8'hFF);
    check(seg_n == 7'h7F, "R1 segments", int'(seg_n), 8'h7F);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_rd_addr == 0, "R1 index", int'(mem_rd_addr), 0);

    expect_frame(0, 0, "zero count");
    press(1, DB * 3);                                  // R6: no movement at count 0
    expect_frame(0, 0, "zero count up R6");

    bad_count = 8'd5;
    expect_frame(5, 0, "count5");
    for (int i = 0; i < 3; i++) begin press(1, DB * 3); exp_idx++; end
    expect_frame(5, exp_idx, "up x3 R8");
    for (int i = 0; i < 3; i++) press(1, DB * 3);
    exp_idx = 4;
    expect_frame(5, exp_idx, "up saturate R8");

    press(0, DB / 2);                                  // glitch, R10
    expect_frame(5, exp_idx, "glitch R10");
    press(0, DB * 10);                                 // long hold, R10
    exp_idx = 3;
    expect_frame(5, exp_idx, "long hold R10");

    for (int i = 0; i < 5; i++) press(0, DB * 3);
    exp_idx = 0;
    expect_frame(5, exp_idx, "down saturate R9");

    bad_count = 8'd123;
    for (int i = 0; i < 7; i++) press(1, DB * 3);
    exp_idx = 7;
    expect_frame(123, exp_idx, "count sat R4");

    bad_count = 8'd3;
    repeat (3) @(negedge clk);
    exp_idx = 2;
    expect_frame(3, exp_idx, "shrink R11");

    bad_count = 8'd47;
    press(1, DB * 3);
    exp_idx = 3;
    expect_frame(47, exp_idx, "count47 R8");

    finish_run();
  end
endmodule